// File: doc/BRIEF.md
# Programmable Comparator Output Glitch Filter

This block cleans up the single-bit output of an analog comparator before the rest of the chip uses it. The raw level is first brought into the peripheral clock domain through a short flop chain. A counter then decides when the output is allowed to follow it. A low-to-high change is passed on only after the synchronized input has stayed high for a programmed number of clock cycles. A high-to-low change has its own, separately programmed count. A pulse that ends before its count is reached is dropped.

Software sets the filter through a small synchronous register port: one write strobe, one address, and a read data bus that shows the addressed register in the same cycle. While the filter is switched off, the output is simply the raw comparator level. When the filter is switched on, it starts from the level it is already seeing, so turning it on produces no edge of its own.

Top module: `cmp_glitch_filter`

## Requirements
- R1: After reset, filt_out is low whenever raw_in is low, and every register reads back as zero.
- R2: While the enable bit (address 0, bit 0) is 0, filt_out equals raw_in in the same cycle, with no clock edge in between.
- R3: With the filter enabled and the rise count (address 1, bits 5:0) set to N, a high level on raw_in reaches filt_out only after the synchronized input has been high at N+1 consecutive clock edges. With a two-flop synchronizer, filt_out goes high N+3 edges after raw_in rises, and a high pulse lasting N edges or fewer never appears.
- R4: With the filter enabled and the fall count (address 2, bits 5:0) set to M, filt_out goes low only after the synchronized input has been low at M+1 consecutive edges, using the same timing as R3.
- R5: If the synchronized input goes back to the current output level before the count completes, the count starts over from zero. Two short pulses separated by a one-cycle gap therefore never add up to a qualified edge.
- R6: The register map is: address 0 holds the enable bit at bit 0, address 1 holds the rise count in bits 5:0, and address 2 holds the fall count in bits 5:0. All other bits, and address 3, read as zero and ignore writes.
- R7: When the enable bit changes from 0 to 1, filt_out keeps the level the synchronized input already has, so no edge is produced.
- R8: If a count field is rewritten while a qualification is in progress, the counter is not restarted. The next comparison uses the new value, and once the running count already meets that value the output changes at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; all counting is in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | 1 | Unsynchronized comparator output |
| reg_addr | input | 2 | Register select: 0 control, 1 rise count, 2 fall count, 3 unused |
| reg_wr | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| filt_out | output | 1 | Filtered comparator level |

## Verification
The bench probes each count value right at its threshold. A pulse one cycle shorter than N+1 must vanish and a pulse of exactly N+1 must pass, for N of 0, an interior value, and 63. An off-by-one in the comparison or in the synchronizer latency shows up as a wrong level at that single sampling point. Two pulses with a one-cycle gap between them catch a counter that fails to clear. Lowering the rise count in the middle of a qualification catches a design that compares for equality: once the count is already past the new limit, such a design would never fire. Turning the filter on while the input is high catches a design that starts from a reset low level and so emits a false rising edge.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      CGF_CTRL  = 2'd0,
      CGF_RISE  = 2'd1,
      CGF_FALL  = 2'd2,
      CGF_SPARE = 2'd3
   } cgf_addr_e;
endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cgf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cgf_regs.sv
module cgf_regs
   import cgf_pkg::*;
#(
   parameter int unsigned REG_W = 16,
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             en,
   output logic [CNT_W-1:0] rise_n,
   output logic [CNT_W-1:0] fall_n
);
   localparam int unsigned PAD_W = REG_W - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W >= REG_W) begin : g_bad_widths
         $error("cgf_regs: CNT_W must lie between 1 and REG_W-1");
      end
   endgenerate

   cgf_addr_e sel;
   assign sel = cgf_addr_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         rise_n <= '0;
         fall_n <= '0;
      end else if (wr) begin
         case (sel)
            CGF_CTRL: en     <= wdata[0];
            CGF_RISE: rise_n <= wdata[CNT_W-1:0];
            CGF_FALL: fall_n <= wdata[CNT_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         CGF_CTRL: rdata = {{(REG_W-1){1'b0}}, en};
         CGF_RISE: rdata = {{PAD_W{1'b0}}, rise_n};
         CGF_FALL: rdata = {{PAD_W{1'b0}}, fall_n};
         default:  rdata = '0;
      endcase
   end

   // R6
   spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:CNT_W] == '0);
endmodule

// File: rtl/cgf_qualifier.sv
module cgf_qualifier #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sync_in,
   input  logic [CNT_W-1:0] rise_n,
   input  logic [CNT_W-1:0] fall_n,
   output logic             level
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = sync_in ? rise_n : fall_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= 1'b0;
         cnt   <= '0;
      end else if (!en) begin
         level <= sync_in;
         cnt   <= '0;
      end else if (sync_in == level) begin
         cnt   <= '0;
      end else if (cnt >= limit) begin
         level <= sync_in;
         cnt   <= '0;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   // R3
   rise_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(level) && $past(en)) |-> ($past(cnt) >= $past(rise_n)));

   // R4
   fall_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(level) && $past(en)) |-> ($past(cnt) >= $past(fall_n)));

   // R5
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && ($past(sync_in) == $past(level))) |-> (cnt == '0));

   // R7
   follow_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level != $past(level)) |-> (level == $past(sync_in)));
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter
   import cgf_pkg::*;
#(
   parameter int unsigned REG_W       = 16,
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                raw_in,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                filt_out
);
   logic             en;
   logic [CNT_W-1:0] rise_n;
   logic [CNT_W-1:0] fall_n;
   logic             sync_lvl;
   logic             qual_lvl;

   cgf_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (reg_addr),
      .wr     (reg_wr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .en     (en),
      .rise_n (rise_n),
      .fall_n (fall_n)
   );

   cgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_lvl)
   );

   cgf_qualifier #(.CNT_W(CNT_W)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .sync_in (sync_lvl),
      .rise_n  (rise_n),
      .fall_n  (fall_n),
      .level   (qual_lvl)
   );

   assign filt_out = en ? qual_lvl : raw_in;

   // R7
   enable_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> (filt_out == $past(sync_lvl)));
endmodule

// File: tb/tb_cmp_glitch_filter.sv
module tb_cmp_glitch_filter;
   localparam real CLK_NS = 20.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        raw_in = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        filt_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_NS/2.0) clk = ~clk;

   cmp_glitch_filter dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (raw_in),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .filt_out  (filt_out)
   );

   // vector: {dir(1: rise test), count(6), hold(7), expect_pass(1)}
   localparam int NV = 10;
   localparam logic [14:0] VEC [NV] = '{
      {1'b1, 6'd0,  7'd1,  1'b1},
      {1'b1, 6'd3,  7'd3,  1'b0},
      {1'b1, 6'd3,  7'd4,  1'b1},
      {1'b1, 6'd63, 7'd63, 1'b0},
      {1'b1, 6'd63, 7'd64, 1'b1},
      {1'b0, 6'd0,  7'd1,  1'b1},
      {1'b0, 6'd5,  7'd5,  1'b0},
      {1'b0, 6'd5,  7'd6,  1'b1},
      {1'b0, 6'd63, 7'd63, 1'b0},
      {1'b0, 6'd63, 7'd64, 1'b1}
   };

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_reg(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(string req, logic [1:0] a, logic [15:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 200000.0);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out", {15'd0, filt_out}, 16'd0);
      rd_check("R1 ctrl", 2'd0, 16'h0000);
      rd_check("R1 rise", 2'd1, 16'h0000);
      rd_check("R1 fall", 2'd2, 16'h0000);

      // R6 register map and spare bits
      wr_reg(2'd0, 16'hFFFF);
      rd_check("R6 ctrl", 2'd0, 16'h0001);
      wr_reg(2'd1, 16'hFFFF);
      rd_check("R6 rise", 2'd1, 16'h003F);
      wr_reg(2'd2, 16'hFFEA);
      rd_check("R6 fall", 2'd2, 16'h002A);
      wr_reg(2'd3, 16'hFFFF);
      rd_check("R6 spare", 2'd3, 16'h0000);
      rd_check("R6 rise kept", 2'd1, 16'h003F);

      // R2 bypass is combinational
      wr_reg(2'd0, 16'h0000);
      raw_in = 1'b1; #1;
      check("R2 high", {15'd0, filt_out}, 16'd1);
      @(negedge clk);
      raw_in = 1'b0; #1;
      check("R2 low", {15'd0, filt_out}, 16'd0);

      // R7 enable while input high: no edge
      raw_in = 1'b1;
      repeat (5) @(negedge clk);
      wr_reg(2'd1, 16'd63);
      wr_reg(2'd0, 16'd1);
      check("R7 on", {15'd0, filt_out}, 16'd1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R7 hold", {15'd0, filt_out}, 16'd1);
      end

      // R3 / R4 threshold vectors
      for (int v = 0; v < NV; v++) begin
         logic dir;
         logic [5:0] n;
         int hold;
         logic pass;
         logic lvl;
         dir  = VEC[v][14];
         n    = VEC[v][13:8];
         hold = int'(VEC[v][7:1]);
         pass = VEC[v][0];
         lvl  = dir;
         wr_reg(2'd1, dir ? {10'd0, n} : 16'd0);
         wr_reg(2'd2, dir ? 16'd0 : {10'd0, n});
         raw_in = ~lvl;
         repeat (70) @(negedge clk);
         check(dir ? "R3 base" : "R4 base", {15'd0, filt_out}, {15'd0, ~lvl});
         raw_in = lvl;
         repeat (hold) @(negedge clk);
         raw_in = ~lvl;
         repeat (2) @(negedge clk);
         check(dir ? "R3 edge" : "R4 edge", {15'd0, filt_out},
               {15'd0, pass ? lvl : ~lvl});
      end

      // R5 interrupted qualification restarts the count
      wr_reg(2'd1, 16'd5);
      wr_reg(2'd2, 16'd0);
      raw_in = 1'b0;
      repeat (10) @(negedge clk);
      raw_in = 1'b1;
      repeat (4) @(negedge clk);
      raw_in = 1'b0;
      @(negedge clk);
      raw_in = 1'b1;
      repeat (4) @(negedge clk);
      raw_in = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check("R5 stays low", {15'd0, filt_out}, 16'd0);
      end

      // R8 count lowered mid-qualification
      wr_reg(2'd1, 16'd20);
      repeat (10) @(negedge clk);
      raw_in = 1'b1;
      repeat (7) @(negedge clk);
      reg_addr = 2'd1; reg_wdata = 16'd1; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      check("R8 before", {15'd0, filt_out}, 16'd0);
      @(negedge clk);
      check("R8 after", {15'd0, filt_out}, 16'd1);

      done = 1'b1;
      finish_run();
   end
endmodule